// File: doc/BRIEF.md
# Codec Serial Port Frame Sequencer

This block is the digital side of a codec's serial port. A DSP serial port connects to it directly. When a frame is requested, it shifts a 16-bit transmit word out on a serial data line, shifts a 16-bit word in from a second line, and drives active-low frame-sync and end-of-data strobes. The strobes let the DSP follow where each frame starts and ends. There are two transmit/receive framers, and each one walks the same frame sequence.

Three formats are supported:

- **Word format:** the word travels in one 16-cycle burst.
- **Byte format:** the word is split into two 8-bit halves, separated by a 4-cycle high pulse on the frame sync.
- **Dual-word format:** a word frame is followed by a secondary slot. During that slot a separate auxiliary serial input is routed to the serial output, and a dedicated slot strobe is low.

In synchronous operation, a single transmit request starts both framers together. In asynchronous operation, each direction has its own request. The received word appears on a parallel output with a one-cycle valid flag.

Top module: `codec_sp_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, all five strobes (`tx_sync_n_o`, `rx_sync_n_o`, `sec_slot_n_o`, `tx_end_n_o`, `rx_end_n_o`) are high and `rx_valid_o` is low.
- R2: Word format. A request sampled at clock edge E0 drives the lane's frame sync low for exactly cycles 1 to 16 after E0. In those cycles, on the transmit lane, `sdo_o` presents `tx_word_i` MSB first, one bit per cycle, with the bit changing at the rising edge.
- R3: Word format. The lane's end strobe is low for exactly one cycle, cycle 17, while the frame sync is already high again.
- R4: Byte format. Frame sync is low in cycles 1 to 8 and 13 to 20, and high in cycles 9 to 12. The end strobe is low in cycles 9 to 20. Both strobes are high from cycle 21. `sdo_o` carries bits 15..8 in cycles 1 to 8 and bits 7..0 in cycles 13 to 20.
- R5: Dual-word format. The primary slot is a word frame, but the end strobes stay high. Cycles 17 to 20 are quiet. In cycles 21 to 36, `sec_slot_n_o` and `tx_sync_n_o` are low, and `sdo_o` follows `aux_sdi_i`.
- R6: During the secondary slot, `rx_sync_n_o` stays high.
- R7: `ctrl_i` encoding:
  - bit 2 = 1 selects synchronous operation;
  - bit 0 = 1 selects byte format and takes precedence;
  - otherwise bit 1 = 1 selects dual-word format;
  - otherwise word format applies.

  The format is captured when a frame starts, and later changes to `ctrl_i` do not affect that frame.
- R8: Synchronous operation. `tx_req_i` starts both framers together, and `rx_sync_n_o` and `tx_sync_n_o` are identical outside the secondary slot.
- R9: Asynchronous operation. `tx_req_i` starts only the transmit strobes and `rx_req_i` starts only the receive strobes. The strobes of the other direction stay high.
- R10: `sdi_i` is sampled on the falling clock edge during the receive lane's data cycles, MSB first. The assembled word appears on `rx_word_o`, and `rx_valid_o` is high for the single cycle after the last primary data cycle: cycle 17 for word and dual-word, cycle 21 for byte.
- R11: A request that arrives while the lane is busy is held. After the lane has returned to idle for one cycle, including after any secondary slot, the held request starts a new frame at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | 3 | Control: bit 2 synchronous, bit 1 dual-word, bit 0 byte |
| tx_req_i | input | 1 | Transmit frame request (starts both lanes when synchronous) |
| rx_req_i | input | 1 | Receive frame request, used only when asynchronous |
| tx_word_i | input | 16 | Parallel word to send, captured at frame start |
| sdi_i | input | 1 | Serial data from the DSP |
| aux_sdi_i | input | 1 | Auxiliary serial data routed out in the secondary slot |
| sdo_o | output | 1 | Serial data to the DSP |
| tx_sync_n_o | output | 1 | Transmit frame sync, active low |
| rx_sync_n_o | output | 1 | Receive frame sync, active low |
| sec_slot_n_o | output | 1 | Secondary slot strobe, active low |
| tx_end_n_o | output | 1 | Transmit end-of-data strobe, active low |
| rx_end_n_o | output | 1 | Receive end-of-data strobe, active low |
| rx_word_o | output | 16 | Last received word |
| rx_valid_o | output | 1 | One-cycle flag marking a new `rx_word_o` |

## Verification
The synchronous-equality property assumes two things:

- `ctrl_i` changes only while both lanes are idle.
- The synchronous bit is never set while a lane started asynchronously is still running.

The stimulus therefore changes `ctrl_i` only between frames, and lets each asynchronous frame finish before it switches mode. The one deliberate exception is a mid-frame change of the format bits with the synchronous bit held. This exercises format latching without breaking lane alignment.

Requests are single-cycle pulses. `sdi_i` is driven shortly after each rising edge, so that it is settled at the falling-edge sample.

// File: rtl/codec_sp_pkg.sv
package codec_sp_pkg;

    localparam int CTRL_W   = 3;
    localparam int BYTE_BIT = 0;
    localparam int DUAL_BIT = 1;
    localparam int SYNC_BIT = 2;

    typedef enum logic [1:0] {
        FMT_WORD = 2'd0,
        FMT_BYTE = 2'd1,
        FMT_DUAL = 2'd2
    } fmt_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_DATA  = 3'd1,
        PH_MID   = 3'd2,
        PH_EOD   = 3'd3,
        PH_SWAIT = 3'd4,
        PH_SDATA = 3'd5
    } phase_e;

    // Byte format wins over dual-word when both bits are set.
    function automatic fmt_e decode_fmt(input logic [CTRL_W-1:0] c);
        if (c[BYTE_BIT])      return FMT_BYTE;
        else if (c[DUAL_BIT]) return FMT_DUAL;
        else                  return FMT_WORD;
    endfunction

endpackage

// File: rtl/codec_sp_framer.sv
module codec_sp_framer
    import codec_sp_pkg::*;
#(
    parameter int W       = 16,
    parameter int GAP     = 4,
    parameter int SEC_GAP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic              fs_n_o,
    output logic              eod_n_o,
    output logic              sec_o,
    output logic              shift_o,
    output logic              start_o
);
    localparam int MAXC = (W > GAP) ? ((W > SEC_GAP) ? W : SEC_GAP)
                                    : ((GAP > SEC_GAP) ? GAP : SEC_GAP);
    localparam int CW   = $clog2(MAXC) + 1;
    localparam int HALF = W / 2;

    phase_e        ph;
    fmt_e          fmt;
    logic [CW-1:0] cnt;
    logic          second;
    logic          pend;
    logic          start;
    logic [CW-1:0] data_last;

    assign start     = (ph == PH_IDLE) && (req_i || pend);
    assign data_last = (fmt == FMT_BYTE) ? CW'(HALF - 1) : CW'(W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            fmt    <= FMT_WORD;
            cnt    <= '0;
            second <= 1'b0;
            pend   <= 1'b0;
        end else begin
            if (req_i && (ph != PH_IDLE)) pend <= 1'b1;
            else if (start)               pend <= 1'b0;

            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph     <= PH_DATA;
                        fmt    <= decode_fmt(ctrl_i);
                        cnt    <= '0;
                        second <= 1'b0;
                    end
                end
                PH_DATA: begin
                    if (cnt == data_last) begin
                        cnt <= '0;
                        if (fmt == FMT_BYTE) ph <= second ? PH_IDLE : PH_MID;
                        else if (fmt == FMT_WORD) ph <= PH_EOD;
                        else ph <= PH_SWAIT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_MID: begin
                    if (cnt == CW'(GAP - 1)) begin
                        cnt    <= '0;
                        second <= 1'b1;
                        ph     <= PH_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_EOD: ph <= PH_IDLE;
                PH_SWAIT: begin
                    if (cnt == CW'(SEC_GAP - 1)) begin
                        cnt <= '0;
                        ph  <= PH_SDATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_SDATA: begin
                    if (cnt == CW'(W - 1)) begin
                        cnt <= '0;
                        ph  <= PH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign fs_n_o  = !((ph == PH_DATA) || (ph == PH_SDATA));
    assign eod_n_o = !((ph == PH_EOD) || (ph == PH_MID) || ((ph == PH_DATA) && second));
    assign sec_o   = (ph == PH_SDATA);
    assign shift_o = (ph == PH_DATA);
    assign start_o = start;

endmodule

// File: rtl/codec_sp_tx_shift.sv
module codec_sp_tx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    input  logic         shift_i,
    output logic         bit_o
);
    logic [W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)          sh <= '0;
        else if (load_i)  sh <= word_i;
        else if (shift_i) sh <= {sh[W-2:0], 1'b0};
    end

    assign bit_o = sh[W-1];

endmodule

// File: rtl/codec_sp_rx_shift.sv
module codec_sp_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         shift_i,
    input  logic         sdi_i,
    output logic [W-1:0] word_o,
    output logic         valid_o
);
    localparam int BW = $clog2(W);

    logic          sdi_q;
    logic [W-1:0]  sh;
    logic [BW-1:0] nbit;

    // Falling-edge sample keeps half a cycle of margin after the sender's rising edge.
    always_ff @(negedge clk) begin
        if (rst) sdi_q <= 1'b0;
        else     sdi_q <= sdi_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            nbit    <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (clear_i) begin
                sh   <= '0;
                nbit <= '0;
            end else if (shift_i) begin
                sh   <= {sh[W-2:0], sdi_q};
                nbit <= nbit + 1'b1;
                if (nbit == BW'(W - 1)) begin
                    word_o  <= {sh[W-2:0], sdi_q};
                    valid_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/codec_sp_seq.sv
module codec_sp_seq
    import codec_sp_pkg::*;
#(
    parameter int W       = 16,
    parameter int GAP     = 4,
    parameter int SEC_GAP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              tx_req_i,
    input  logic              rx_req_i,
    input  logic [W-1:0]      tx_word_i,
    input  logic              sdi_i,
    input  logic              aux_sdi_i,
    output logic              sdo_o,
    output logic              tx_sync_n_o,
    output logic              rx_sync_n_o,
    output logic              sec_slot_n_o,
    output logic              tx_end_n_o,
    output logic              rx_end_n_o,
    output logic [W-1:0]      rx_word_o,
    output logic              rx_valid_o
);
    localparam int LANES = 2;
    localparam int TXL   = 0;
    localparam int RXL   = 1;

    logic [LANES-1:0] req_v, fs_n_v, eod_n_v, sec_v, shift_v, start_v;
    logic             tx_bit;

    assign req_v[TXL] = tx_req_i;
    assign req_v[RXL] = ctrl_i[SYNC_BIT] ? tx_req_i : rx_req_i;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        codec_sp_framer #(.W(W), .GAP(GAP), .SEC_GAP(SEC_GAP)) u_frm (
            .clk     (clk),
            .rst     (rst),
            .req_i   (req_v[g]),
            .ctrl_i  (ctrl_i),
            .fs_n_o  (fs_n_v[g]),
            .eod_n_o (eod_n_v[g]),
            .sec_o   (sec_v[g]),
            .shift_o (shift_v[g]),
            .start_o (start_v[g])
        );
    end

    codec_sp_tx_shift #(.W(W)) u_txs (
        .clk     (clk),
        .rst     (rst),
        .load_i  (start_v[TXL]),
        .word_i  (tx_word_i),
        .shift_i (shift_v[TXL]),
        .bit_o   (tx_bit)
    );

    codec_sp_rx_shift #(.W(W)) u_rxs (
        .clk     (clk),
        .rst     (rst),
        .clear_i (start_v[RXL]),
        .shift_i (shift_v[RXL]),
        .sdi_i   (sdi_i),
        .word_o  (rx_word_o),
        .valid_o (rx_valid_o)
    );

    assign sdo_o        = sec_v[TXL] ? aux_sdi_i : tx_bit;
    assign tx_sync_n_o  = fs_n_v[TXL];
    assign rx_sync_n_o  = fs_n_v[RXL] | sec_v[RXL];
    assign sec_slot_n_o = ~sec_v[TXL];
    assign tx_end_n_o   = eod_n_v[TXL];
    assign rx_end_n_o   = eod_n_v[RXL];

endmodule

// File: rtl/codec_sp_chk.sv
module codec_sp_chk
    import codec_sp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CTRL_W-1:0] ctrl_i,
    input logic              tx_sync_n_o,
    input logic              rx_sync_n_o,
    input logic              sec_slot_n_o,
    input logic              tx_end_n_o,
    input logic              rx_end_n_o,
    input logic              rx_valid_o
);
    // R5: the secondary slot strobe only appears inside a transmit frame sync
    p_sec_in_txsync_r5: assert property (@(posedge clk) disable iff (rst)
        !sec_slot_n_o |-> !tx_sync_n_o);

    // R6: receive frame sync is quiet during the secondary slot
    p_rxsync_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !sec_slot_n_o |-> rx_sync_n_o);

    // R5: no end strobes in the secondary slot
    p_eod_quiet_sec_r5: assert property (@(posedge clk) disable iff (rst)
        !sec_slot_n_o |-> (tx_end_n_o && rx_end_n_o));

    // R3: an end strobe only starts while the frame sync is high
    p_eod_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_end_n_o) |-> tx_sync_n_o);

    // R4: the end strobe is released with the frame sync high
    p_eod_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_end_n_o) |-> rx_sync_n_o);

    // R10: valid is a single-cycle pulse
    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    // R8: synchronous lanes share the primary frame sync
    p_sync_match_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i[SYNC_BIT] && $stable(ctrl_i) && sec_slot_n_o) |-> (tx_sync_n_o == rx_sync_n_o));

endmodule

bind codec_sp_seq codec_sp_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctrl_i       (ctrl_i),
    .tx_sync_n_o  (tx_sync_n_o),
    .rx_sync_n_o  (rx_sync_n_o),
    .sec_slot_n_o (sec_slot_n_o),
    .tx_end_n_o   (tx_end_n_o),
    .rx_end_n_o   (rx_end_n_o),
    .rx_valid_o   (rx_valid_o)
);

// File: tb/tb_codec_sp_seq.sv
module tb_codec_sp_seq;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int NVEC       = 5;

    // {ctrl[2:0], tx word, rx word}
    localparam logic [34:0] VEC [NVEC] = '{
        {3'b100, 16'hA53C, 16'h9E21},
        {3'b101, 16'h81F0, 16'h5AA5},
        {3'b110, 16'hC3E7, 16'h1248},
        {3'b111, 16'h7E01, 16'hFF00},
        {3'b100, 16'h0001, 16'h8000}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   ctrl_i = 3'b100;
    logic         tx_req_i = 1'b0, rx_req_i = 1'b0;
    logic [W-1:0] tx_word_i = '0;
    logic         sdi_i = 1'b0, aux_sdi_i = 1'b0;
    logic         sdo_o, tx_sync_n_o, rx_sync_n_o, sec_slot_n_o, tx_end_n_o, rx_end_n_o;
    logic [W-1:0] rx_word_o;
    logic         rx_valid_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    codec_sp_seq dut (
        .clk(clk), .rst(rst), .ctrl_i(ctrl_i), .tx_req_i(tx_req_i), .rx_req_i(rx_req_i),
        .tx_word_i(tx_word_i), .sdi_i(sdi_i), .aux_sdi_i(aux_sdi_i), .sdo_o(sdo_o),
        .tx_sync_n_o(tx_sync_n_o), .rx_sync_n_o(rx_sync_n_o), .sec_slot_n_o(sec_slot_n_o),
        .tx_end_n_o(tx_end_n_o), .rx_end_n_o(rx_end_n_o), .rx_word_o(rx_word_o),
        .rx_valid_o(rx_valid_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: act %0d cycles exp done", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: act %h exp %h (t=%0t)", rq, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // format from R7: 0 word, 1 byte, 2 dual
    function automatic int fmt_of(input logic [2:0] c);
        if (c[0]) return 1;
        if (c[1]) return 2;
        return 0;
    endfunction

    function automatic bit pri_on(input int m, input int k);
        if (m == 1) return (k >= 1 && k <= 8) || (k >= 13 && k <= 20);
        return (k >= 1 && k <= 16);
    endfunction

    function automatic bit sec_on(input int m, input int k);
        return (m == 2) && (k >= 21) && (k <= 36);
    endfunction

    function automatic bit eod_on(input int m, input int k);
        if (m == 0) return (k == 17);
        if (m == 1) return (k >= 9 && k <= 20);
        return 1'b0;
    endfunction

    function automatic int bit_idx(input int m, input int k);
        if (m == 1 && k >= 13) return 20 - k;
        return 16 - k;
    endfunction

    task automatic run_frame(input logic [2:0] c, input logic [W-1:0] txw,
                             input logic [W-1:0] rxw, input bit drx, input bit drr);
        int  m     = fmt_of(c);
        bit  ax    = drx;
        bit  ar    = c[2] ? drx : drr;
        int  vcyc  = (m == 1) ? 21 : 17;
        int  n     = (m == 2) ? 37 : vcyc;
        ctrl_i    = c;
        tx_word_i = txw;
        tx_req_i  = drx;
        rx_req_i  = drr;
        step();
        tx_req_i = 1'b0;
        rx_req_i = 1'b0;
        for (int k = 1; k <= n; k++) begin
            sdi_i     = pri_on(m, k) ? rxw[bit_idx(m, k)] : 1'b0;
            aux_sdi_i = k[0] ^ k[2];
            #1;
            chk("R2/R4/R5/R9 tx_sync", {15'd0, tx_sync_n_o},
                {15'd0, !(ax && (pri_on(m, k) || sec_on(m, k)))});
            chk("R6/R8/R9 rx_sync", {15'd0, rx_sync_n_o}, {15'd0, !(ar && pri_on(m, k))});
            chk("R3/R4/R5 tx_end", {15'd0, tx_end_n_o}, {15'd0, !(ax && eod_on(m, k))});
            chk("R3/R4/R5 rx_end", {15'd0, rx_end_n_o}, {15'd0, !(ar && eod_on(m, k))});
            chk("R5 sec_slot", {15'd0, sec_slot_n_o}, {15'd0, !(ax && sec_on(m, k))});
            if (ax && pri_on(m, k))
                chk("R2/R4 sdo data", {15'd0, sdo_o}, {15'd0, txw[bit_idx(m, k)]});
            if (ax && sec_on(m, k))
                chk("R5 sdo aux", {15'd0, sdo_o}, {15'd0, aux_sdi_i});
            chk("R10 rx_valid", {15'd0, rx_valid_o}, {15'd0, ar && (k == vcyc)});
            if (ar && k == vcyc) chk("R10 rx_word", rx_word_o, rxw);
            step();
        end
    endtask

    initial begin
        #2;
        repeat (3) step();
        chk("R1 strobes in reset", {11'd0, tx_sync_n_o, rx_sync_n_o, sec_slot_n_o, tx_end_n_o, rx_end_n_o},
            16'h001F);
        rst = 1'b0;
        step();
        chk("R1 strobes after reset", {11'd0, tx_sync_n_o, rx_sync_n_o, sec_slot_n_o, tx_end_n_o, rx_end_n_o},
            16'h001F);
        chk("R1 rx_valid after reset", {15'd0, rx_valid_o}, 16'd0);

        // table walk: synchronous frames in every format (R2 R3 R4 R5 R6 R7 R8 R10)
        for (int i = 0; i < NVEC; i++) begin
            run_frame(VEC[i][34:32], VEC[i][31:16], VEC[i][15:0], 1'b1, 1'b0);
            step();
        end

        // R9: asynchronous, each direction on its own request
        run_frame(3'b000, 16'h1357, 16'hBEEF, 1'b0, 1'b1);
        step();
        run_frame(3'b000, 16'h2468, 16'h0000, 1'b1, 1'b0);
        step();
        run_frame(3'b001, 16'hF00F, 16'h6C39, 1'b0, 1'b1);
        step();

        // R11 + R7 latching: word frame, held request, format changed mid-frame
        ctrl_i   = 3'b100;
        tx_req_i = 1'b1;
        step();
        tx_req_i = 1'b0;
        for (int k = 1; k <= 42; k++) begin
            if (k == 3) ctrl_i = 3'b101;
            tx_req_i = (k == 5);
            #1;
            if (k == 9)  chk("R7 format latched at start", {15'd0, tx_sync_n_o}, 16'd0);
            if (k == 17) chk("R3 word end pulse", {15'd0, tx_end_n_o}, 16'd0);
            if (k == 18) chk("R11 idle gap before held frame", {15'd0, tx_sync_n_o}, 16'd1);
            if (k == 19) chk("R11 held frame starts", {15'd0, tx_sync_n_o}, 16'd0);
            if (k == 27) chk("R7 new format on next frame", {14'd0, tx_sync_n_o, tx_end_n_o}, 16'd2);
            if (k == 39) chk("R4 both high after byte frame", {14'd0, tx_sync_n_o, tx_end_n_o}, 16'd3);
            step();
        end
        tx_req_i = 1'b0;

        // R11: request during the secondary slot waits for its end
        ctrl_i   = 3'b110;
        tx_req_i = 1'b1;
        step();
        tx_req_i = 1'b0;
        for (int k = 1; k <= 78; k++) begin
            tx_req_i = (k == 25);
            #1;
            if (k == 36) chk("R11 slot still running", {15'd0, sec_slot_n_o}, 16'd0);
            if (k == 37) chk("R11 idle after slot", {14'd0, tx_sync_n_o, sec_slot_n_o}, 16'd3);
            if (k == 38) chk("R11 held frame after slot", {14'd0, tx_sync_n_o, sec_slot_n_o}, 16'd1);
            if (k == 58) chk("R6 rx_sync high in slot", {15'd0, rx_sync_n_o}, 16'd1);
            step();
        end
        tx_req_i = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule